// File: doc/BRIEF.md
# Multi-format PCM slot transmitter

This block places up to six parallel PCM channel words on a shared serial audio data line. It works as a bus slave: an external bit clock and frame sync arrive already synchronous to the system clock. The block oversamples them, finds the transmit edge of the bit clock and the reference edges of the frame sync, and counts bits and slots from those edges. One time-division framing and two stereo framings, standard stereo (I2S) and left-justified, are supported.

Each channel has an enable, a 6-bit slot number and a 32-bit sample input. The word length can be 16, 20, 24 or 32 bits, and the slot width always equals it. The data start can be delayed by up to 31 bit clocks after the standard protocol point. Either clock polarity or frame-sync polarity can be inverted. The output enable is raised only on bits that an enabled channel owns, so several transmitters can share one line.

Top module: `pcm_slot_tx`

## Requirements
- R1: While reset is low and afterwards, `sd_out` and `sd_oe` stay 0 until the first frame reference edge has been seen at a transmit edge.
- R2: `fmt` selects the framing: 00 time-division, 01 I2S, 10 left-justified. Code 11 is reserved, and with it `sd_oe` never rises.
- R3: `wlen_sel` 00/01/10/11 selects 16/20/24/32-bit words and slots. A channel sends the top W bits of its 32-bit sample, starting with bit 31.
- R4: In time-division mode, with offset O and word length W, bit k of slot s is driven at transmit edge number 1+O+s*W+k. Edge 0 is the transmit edge at which frame sync is first sampled high.
- R5: In left-justified mode, the left half starts at the transmit edge where frame sync is first sampled high, and the right half starts where it is first sampled low. Each half is delayed by O.
- R6: In I2S mode, the left half starts one transmit edge after frame sync is first sampled low, and the right half starts one edge after it is first sampled high. Each half is delayed by O.
- R7: In time-division mode, the slot field addresses slots 0–63 directly. In the stereo modes, slot bit 5 picks the half (0 left, 1 right) and bits 4:0 pick the slot within that half.
- R8: `start_offset` (0–31) delays the data start by that many bit clocks in every mode and in both stereo halves.
- R9: With `bclk_inv`=0, data changes on falling bit-clock edges; with `bclk_inv`=1, it changes on rising edges. `fs_inv`=1 inverts frame sync before edge detection.
- R10: `sd_oe` is 1 only during a bit owned by an enabled channel. Otherwise `sd_oe` and `sd_out` are 0. Both outputs change only after a transmit edge.
- R11: When several enabled channels claim the same slot, the lowest-numbered channel is sent.
- R12: All samples are captured at frame start (the time-division reference or the left-half reference). Sample changes later in the frame do not alter the bits sent in that frame.
- R13: Bits after the last slot (slot 64 in time-division, slot 32 of a half in the stereo modes) are not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Bit clock, synchronous to clk |
| fsync_in | input | 1 | Frame sync, synchronous to clk |
| fmt | input | 2 | Framing select |
| wlen_sel | input | 2 | Word length select |
| start_offset | input | 5 | Data start delay in bit clocks |
| bclk_inv | input | 1 | Transmit on rising bit-clock edges |
| fs_inv | input | 1 | Invert frame-sync polarity |
| ch_en | input | 6 | Per-channel enable |
| ch_slot | input | 36 | Six 6-bit slot numbers, channel 0 in the low bits |
| ch_data | input | 192 | Six 32-bit samples, channel 0 in the low bits |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Output enable for the shared data line |

## Verification
The bench sweeps all three framings against every word length and three offsets, including the maximum of 31. A bench-side arithmetic model finds the slot and bit with division, so a counter that miscounts a 20- or 24-bit slot, or that starts one edge early or late, shows up as a shifted bit stream. Separate runs cover these cases: two channels on one slot, where a wrong priority sends the wrong channel; a sample change in mid-frame, where missing capture corrupts the tail of the frame; long frames past slot 63 and past slot 31 of a half, where a missing stop wraps around and drives the line again; both polarity inversions, where a design using the wrong edge shifts every bit; and the reserved format, which must leave the line undriven.

// File: rtl/pcm_slot_tx_pkg.sv
// Shared types and helpers for the PCM slot transmitter.
package pcm_slot_tx_pkg;

    typedef enum logic [1:0] {
        FMT_TDM  = 2'b00,
        FMT_I2S  = 2'b01,
        FMT_LJ   = 2'b10,
        FMT_RSVD = 2'b11
    } tx_fmt_e;

    // Bits per slot for a word-length code.
    function automatic logic [5:0] word_bits(input logic [1:0] sel);
        case (sel)
            2'b00:   word_bits = 6'd16;
            2'b01:   word_bits = 6'd20;
            2'b10:   word_bits = 6'd24;
            default: word_bits = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/pcm_slot_tx_edge.sv
// Finds transmit edges of the bit clock and the frame-sync transitions seen on them.
// Assumes bclk_in and fsync_in are already synchronous to clk and that each
// bit-clock level lasts at least one clk cycle.
module pcm_slot_tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic fsync_in,
    input  logic bclk_inv,
    input  logic fs_inv,
    output logic tick,
    output logic fs_rise,
    output logic fs_fall
);

    logic bclk_q;
    logic fs_q;
    logic fs_now;

    // Detect the transmit edge and the normalized frame-sync change at it.
    always_comb begin
        fs_now  = fsync_in ^ fs_inv;
        tick    = bclk_inv ? (bclk_in & ~bclk_q) : (~bclk_in & bclk_q);
        fs_rise = tick & fs_now & ~fs_q;
        fs_fall = tick & ~fs_now & fs_q;
    end

    // Keep the previous clock level and the frame-sync level of the last transmit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= bclk_in;
            fs_q   <= fs_now;
        end else begin
            bclk_q <= bclk_in;
            if (tick) fs_q <= fs_now;
        end
    end

endmodule

// File: rtl/pcm_slot_tx_timing.sv
// Lead-in, bit and slot counters for one frame or stereo half.
// Assumes fs_rise/fs_fall are only asserted together with tick.
module pcm_slot_tx_timing
    import pcm_slot_tx_pkg::*;
#(
    parameter int SLOT_W = 6,
    parameter int OFF_W  = 5,
    parameter int BIT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fs_rise,
    input  logic              fs_fall,
    input  logic [1:0]        fmt,
    input  logic [1:0]        wlen_sel,
    input  logic [OFF_W-1:0]  offset,
    output logic              active,
    output logic              frame_start,
    output logic [SLOT_W-1:0] slot_key,
    output logic [BIT_W-1:0]  bit_idx
);

    localparam int SLOT_CNT_W = SLOT_W + 1;
    localparam int NUM_SLOTS  = 1 << SLOT_W;
    localparam int HALF_SLOTS = NUM_SLOTS / 2;
    localparam int LEAD_W     = OFF_W + 1;

    logic [LEAD_W-1:0]     lead_q, c_lead, delay;
    logic [BIT_W-1:0]      bit_q, c_bit;
    logic [SLOT_CNT_W-1:0] slot_q, c_slot, limit;
    logic                  half_q, c_half;
    logic                  ref_ev, ref_half, fmt_ok, in_slots;
    logic [5:0]            wl;

    // Decode reference edges per framing and form this edge's counter view.
    always_comb begin
        ref_ev   = 1'b0;
        ref_half = 1'b0;
        delay    = '0;
        fmt_ok   = 1'b1;
        case (tx_fmt_e'(fmt))
            FMT_TDM: begin ref_ev = fs_rise;           ref_half = 1'b0;    delay = LEAD_W'(1); end
            FMT_I2S: begin ref_ev = fs_rise | fs_fall; ref_half = fs_rise; delay = LEAD_W'(1); end
            FMT_LJ:  begin ref_ev = fs_rise | fs_fall; ref_half = fs_fall; delay = '0;         end
            default: fmt_ok = 1'b0;
        endcase
        frame_start = ref_ev & ~ref_half;
        c_lead   = ref_ev ? delay + LEAD_W'(offset) : lead_q;
        c_bit    = ref_ev ? '0 : bit_q;
        c_slot   = ref_ev ? '0 : slot_q;
        c_half   = ref_ev ? ref_half : half_q;
        limit    = (tx_fmt_e'(fmt) == FMT_TDM) ? SLOT_CNT_W'(NUM_SLOTS) : SLOT_CNT_W'(HALF_SLOTS);
        in_slots = fmt_ok && (c_lead == '0) && (c_slot < limit);
        active   = tick & in_slots;
        wl       = word_bits(wlen_sel);
        bit_idx  = c_bit;
        slot_key = (tx_fmt_e'(fmt) == FMT_TDM) ? c_slot[SLOT_W-1:0]
                                              : {c_half, c_slot[SLOT_W-2:0]};
    end

    // Advance lead-in, then bit within slot, then slot, on each transmit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lead_q <= '0;
            bit_q  <= '0;
            slot_q <= SLOT_CNT_W'(NUM_SLOTS);
            half_q <= 1'b0;
        end else if (tick) begin
            half_q <= c_half;
            bit_q  <= c_bit;
            slot_q <= c_slot;
            lead_q <= '0;
            if (c_lead != '0) begin
                lead_q <= c_lead - 1'b1;
            end else if (in_slots) begin
                if ({1'b0, c_bit} == wl - 6'd1) begin
                    bit_q  <= '0;
                    slot_q <= c_slot + 1'b1;
                end else begin
                    bit_q <= c_bit + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pcm_slot_tx_owner.sv
// Picks the lowest-numbered enabled channel whose slot matches the current key.
module pcm_slot_tx_owner #(
    parameter int NUM_CH   = 6,
    parameter int SLOT_W   = 6,
    parameter int CH_IDX_W = 3
) (
    input  logic [NUM_CH*SLOT_W-1:0] ch_slot,
    input  logic [NUM_CH-1:0]        ch_en,
    input  logic [SLOT_W-1:0]        key,
    output logic                     hit,
    output logic [CH_IDX_W-1:0]      sel
);

    logic [NUM_CH-1:0] match;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_match
        assign match[g] = ch_en[g] && (ch_slot[g*SLOT_W +: SLOT_W] == key);
    end

    // Priority encode, lowest index last so it wins.
    always_comb begin
        hit = |match;
        sel = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (match[i]) sel = CH_IDX_W'(i);
        end
    end

endmodule

// File: rtl/pcm_slot_tx.sv
// Slave-mode serializer of per-channel PCM words onto a shared serial line.
// Assumes bus clocks are synchronous to clk and each bit-clock phase spans at
// least one clk cycle; outputs are registered one clk after the transmit edge.
module pcm_slot_tx
    import pcm_slot_tx_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int MAX_W  = 32,
    parameter int SLOT_W = 6,
    parameter int OFF_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bclk_in,
    input  logic                     fsync_in,
    input  logic [1:0]               fmt,
    input  logic [1:0]               wlen_sel,
    input  logic [OFF_W-1:0]         start_offset,
    input  logic                     bclk_inv,
    input  logic                     fs_inv,
    input  logic [NUM_CH-1:0]        ch_en,
    input  logic [NUM_CH*SLOT_W-1:0] ch_slot,
    input  logic [NUM_CH*MAX_W-1:0]  ch_data,
    output logic                     sd_out,
    output logic                     sd_oe
);

    localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int BIT_W    = $clog2(MAX_W);
    localparam int IDX_W    = $clog2(NUM_CH * MAX_W);

    logic                    tick, fs_rise, fs_fall;
    logic                    active, frame_start, hit, tx_bit;
    logic [SLOT_W-1:0]       slot_key;
    logic [BIT_W-1:0]        bit_idx;
    logic [CH_IDX_W-1:0]     sel;
    logic [IDX_W-1:0]        bit_pos;
    logic [NUM_CH*MAX_W-1:0] hold_q, src;

    pcm_slot_tx_edge u_edge (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fsync_in(fsync_in),
        .bclk_inv(bclk_inv), .fs_inv(fs_inv),
        .tick(tick), .fs_rise(fs_rise), .fs_fall(fs_fall)
    );

    pcm_slot_tx_timing #(.SLOT_W(SLOT_W), .OFF_W(OFF_W), .BIT_W(BIT_W)) u_timing (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fs_rise(fs_rise), .fs_fall(fs_fall),
        .fmt(fmt), .wlen_sel(wlen_sel), .offset(start_offset),
        .active(active), .frame_start(frame_start), .slot_key(slot_key), .bit_idx(bit_idx)
    );

    pcm_slot_tx_owner #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .CH_IDX_W(CH_IDX_W)) u_owner (
        .ch_slot(ch_slot), .ch_en(ch_en), .key(slot_key), .hit(hit), .sel(sel)
    );

    // Capture every channel's sample at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)                  hold_q <= '0;
        else if (tick && frame_start) hold_q <= ch_data;
    end

    // Select the bit of the owning channel, using live data on the capture edge.
    always_comb begin
        src     = frame_start ? ch_data : hold_q;
        bit_pos = IDX_W'(sel) * IDX_W'(MAX_W) + IDX_W'(MAX_W - 1) - IDX_W'(bit_idx);
        tx_bit  = src[bit_pos];
    end

    // Update the line driver only on transmit edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_out <= 1'b0;
            sd_oe  <= 1'b0;
        end else if (tick) begin
            sd_out <= active & hit & tx_bit;
            sd_oe  <= active & hit;
        end
    end

endmodule

// File: rtl/pcm_slot_tx_chk.sv
// Protocol checker bound to pcm_slot_tx.
module pcm_slot_tx_chk
    import pcm_slot_tx_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int MAX_W  = 32,
    parameter int BIT_W  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick,
    input logic                    frame_start,
    input logic                    active,
    input logic [BIT_W-1:0]        bit_idx,
    input logic [1:0]              wlen_sel,
    input logic [1:0]              fmt,
    input logic [NUM_CH*MAX_W-1:0] ch_data,
    input logic [NUM_CH*MAX_W-1:0] hold_q,
    input logic                    sd_out,
    input logic                    sd_oe
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!sd_oe && !sd_out));

    // R10
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(sd_out) && $stable(sd_oe)));

    // R2
    reserved_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fmt == 2'b11) |=> !sd_oe);

    // R12
    frame_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frame_start) |=> (hold_q == $past(ch_data)));

    // R3
    bit_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ({1'b0, bit_idx} < word_bits(wlen_sel)));

endmodule

bind pcm_slot_tx pcm_slot_tx_chk #(.NUM_CH(NUM_CH), .MAX_W(MAX_W), .BIT_W(BIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frame_start(frame_start), .active(active),
    .bit_idx(bit_idx), .wlen_sel(wlen_sel), .fmt(fmt), .ch_data(ch_data),
    .hold_q(hold_q), .sd_out(sd_out), .sd_oe(sd_oe)
);

// File: tb/pcm_slot_tx_bench.sv
module pcm_slot_tx_bench;

    localparam int CLK_P = 10;
    localparam int NCH   = 6;
    localparam int WD    = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk_in = 1'b1;
    logic         fsync_in = 1'b0;
    logic [1:0]   fmt = 2'b00;
    logic [1:0]   wlen_sel = 2'b11;
    logic [4:0]   start_offset = '0;
    logic         bclk_inv = 1'b0;
    logic         fs_inv = 1'b0;
    logic [5:0]   ch_en = 6'h3f;
    logic [35:0]  ch_slot;
    logic [191:0] ch_data;
    logic         sd_out, sd_oe;

    logic [5:0]   s_slot [NCH];
    logic [31:0]  dat    [NCH];
    logic [31:0]  m_hold [NCH];
    int           m_pos;
    int           m_half;
    logic         m_prev;
    int           n_chk = 0;
    int           n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            ch_slot[c*6 +: 6]  = s_slot[c];
            ch_data[c*32 +: 32] = dat[c];
        end
    end

    pcm_slot_tx u_pcm_slot_tx (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fsync_in(fsync_in),
        .fmt(fmt), .wlen_sel(wlen_sel), .start_offset(start_offset),
        .bclk_inv(bclk_inv), .fs_inv(fs_inv), .ch_en(ch_en), .ch_slot(ch_slot),
        .ch_data(ch_data), .sd_out(sd_out), .sd_oe(sd_oe)
    );

    task automatic set_data(input int seed);
        for (int c = 0; c < NCH; c++)
            dat[c] = (32'h9E3779B9 * 32'(seed * 8 + c + 1)) ^ 32'h5A5A0F0F;
    endtask

    task automatic apply_reset(input logic lvl);
        rst_n    = 1'b0;
        bclk_in  = bclk_inv ? 1'b0 : 1'b1;
        fsync_in = lvl ^ fs_inv;
        m_prev   = lvl;
        m_pos    = 1000000;
        m_half   = 0;
        for (int c = 0; c < NCH; c++) m_hold[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (sd_oe !== 1'b0 || sd_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 after reset: oe=%b sd=%b expected oe=0 sd=0", sd_oe, sd_out);
        end
    endtask

    // Bench model of one transmit edge; also drives the bus and compares.
    task automatic do_tick(input logic fsn, input string tag);
        logic ref_ev;
        int   half, del, b, s, k, wl, lim, key;
        logic exp_oe, exp_sd;
        @(negedge clk);
        bclk_in = bclk_inv ? 1'b0 : 1'b1;
        @(negedge clk);
        bclk_in  = bclk_inv ? 1'b1 : 1'b0;
        fsync_in = fsn ^ fs_inv;
        ref_ev = 1'b0; half = 0; del = 0;
        case (fmt)
            2'b00: begin del = 1; if (fsn && !m_prev) ref_ev = 1'b1; end
            2'b01: begin del = 1; if (fsn != m_prev) begin ref_ev = 1'b1; half = fsn ? 1 : 0; end end
            2'b10: begin del = 0; if (fsn != m_prev) begin ref_ev = 1'b1; half = fsn ? 0 : 1; end end
            default: ;
        endcase
        m_prev = fsn;
        if (ref_ev) begin
            m_pos = 0; m_half = half;
            if (half == 0) for (int c = 0; c < NCH; c++) m_hold[c] = dat[c];
        end else if (m_pos < 1000000) begin
            m_pos++;
        end
        exp_oe = 1'b0; exp_sd = 1'b0;
        wl  = 16 + 4 * int'(wlen_sel) + ((wlen_sel == 2'b11) ? 4 : 0);
        lim = (fmt == 2'b00) ? 64 : 32;
        b   = m_pos - del - int'(start_offset);
        if (fmt != 2'b11 && b >= 0) begin
            s = b / wl; k = b % wl;
            if (s < lim) begin
                key = (fmt == 2'b00) ? s : m_half * 32 + s;
                for (int c = NCH - 1; c >= 0; c--) begin
                    if (ch_en[c] && int'(s_slot[c]) == key) begin
                        exp_oe = 1'b1; exp_sd = m_hold[c][31 - k];
                    end
                end
            end
        end
        @(negedge clk);
        n_chk++;
        if (sd_oe !== exp_oe || sd_out !== exp_sd) begin
            n_bad++;
            $display("FAIL %s pos=%0d: oe=%b sd=%b expected oe=%b sd=%b",
                     tag, m_pos, sd_oe, sd_out, exp_oe, exp_sd);
        end
    endtask

    task automatic run_frame(input int len, input int seed, input int mid, input string tag);
        set_data(seed);
        if (fmt == 2'b00 || fmt == 2'b11) begin
            for (int t = 0; t < len; t++) begin
                if (mid != 0 && t == len / 2) set_data(seed + 77);
                do_tick(t == 0, tag);
            end
        end else begin
            for (int t = 0; t < 2 * len; t++) begin
                if (mid != 0 && t == len / 2) set_data(seed + 77);
                do_tick((fmt == 2'b01) ? (t >= len) : (t < len), tag);
            end
        end
    endtask

    task automatic slots_tdm();
        s_slot[0] = 6'd0; s_slot[1] = 6'd2; s_slot[2] = 6'd3;
        s_slot[3] = 6'd5; s_slot[4] = 6'd7; s_slot[5] = 6'd63;
    endtask

    task automatic slots_lr();
        s_slot[0] = 6'd0;  s_slot[1] = 6'd33; s_slot[2] = 6'd2;
        s_slot[3] = 6'd32; s_slot[4] = 6'd35; s_slot[5] = 6'd1;
    endtask

    function automatic int wbits(input logic [1:0] w);
        return (w == 2'b00) ? 16 : (w == 2'b01) ? 20 : (w == 2'b10) ? 24 : 32;
    endfunction

    initial begin
        slots_tdm();
        set_data(0);
        apply_reset(1'b0);
        // Sweep framings, word lengths and offsets: R3 R4 R5 R6 R7 R8 R10
        for (int f = 0; f < 3; f++) begin
            for (int w = 0; w < 4; w++) begin
                for (int oi = 0; oi < 3; oi++) begin
                    int len;
                    string tag;
                    fmt = 2'(f); wlen_sel = 2'(w);
                    start_offset = (oi == 0) ? 5'd0 : (oi == 1) ? 5'd5 : 5'd31;
                    if (f == 0) begin slots_tdm(); tag = "R4 R3 R7 R8 R10"; end
                    else if (f == 1) begin slots_lr(); tag = "R6 R3 R7 R8 R10"; end
                    else begin slots_lr(); tag = "R5 R3 R7 R8 R10"; end
                    apply_reset(f == 1);
                    len = (f == 0) ? (1 + int'(start_offset) + 8 * wbits(2'(w)) + 2)
                                   : (1 + int'(start_offset) + 4 * wbits(2'(w)) + 2);
                    run_frame(len, f * 100 + w * 10 + oi, 0, tag);
                    run_frame(len, f * 100 + w * 10 + oi + 1, 0, tag);
                end
            end
        end
        // R11: shared slot, lowest enabled channel wins
        fmt = 2'b00; wlen_sel = 2'b00; start_offset = 5'd2;
        slots_tdm(); s_slot[1] = 6'd0; s_slot[4] = 6'd0;
        ch_en = 6'b111110;
        apply_reset(1'b0);
        run_frame(1 + 2 + 8 * 16 + 2, 500, 0, "R11");
        ch_en = 6'b111100;
        run_frame(1 + 2 + 8 * 16 + 2, 501, 0, "R11");
        ch_en = 6'h3f;
        // R2: reserved format drives nothing
        fmt = 2'b11; slots_tdm();
        apply_reset(1'b0);
        run_frame(40, 600, 0, "R2");
        // R9: both polarities inverted
        fmt = 2'b01; wlen_sel = 2'b00; start_offset = 5'd2;
        bclk_inv = 1'b1; fs_inv = 1'b1; slots_lr();
        apply_reset(1'b1);
        run_frame(1 + 2 + 4 * 16 + 2, 700, 0, "R9");
        run_frame(1 + 2 + 4 * 16 + 2, 701, 0, "R9");
        bclk_inv = 1'b0; fs_inv = 1'b0;
        // R12: sample change in mid-frame does not reach the line
        fmt = 2'b00; wlen_sel = 2'b10; start_offset = 5'd0; slots_tdm();
        apply_reset(1'b0);
        run_frame(1 + 8 * 24 + 2, 800, 1, "R12");
        fmt = 2'b10; slots_lr();
        apply_reset(1'b0);
        run_frame(1 + 4 * 24 + 2, 810, 1, "R12");
        // R13: run past the last slot in both kinds of framing
        fmt = 2'b00; wlen_sel = 2'b00; start_offset = 5'd0;
        slots_tdm(); s_slot[0] = 6'd62;
        apply_reset(1'b0);
        run_frame(1 + 64 * 16 + 6, 900, 0, "R13 R4");
        fmt = 2'b01; slots_lr(); s_slot[0] = 6'd31; s_slot[1] = 6'd63;
        apply_reset(1'b1);
        run_frame(1 + 32 * 16 + 4, 910, 0, "R13 R6");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion before %0d cycles", WD);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule